// File: doc/BRIEF.md
# Paged Window Address Translator

This block remaps memory requests that land inside a window of 64 equal pages. Each page has its own table entry, which holds a replacement base address and two control flags. One flag marks the entry as usable. The other allows prefetching on reads. For a request that hits a usable entry, the block keeps the offset within the page and puts the entry's base above it.

A request that lands on an unusable entry is refused, and how it is refused is set by configuration. A refused write is dropped and can raise an error pulse. A refused read either returns all-ones data or reports a target abort. When a transfer with a usable entry touches the final Dword of its page, the block sets that page's event bit. Any event whose mask bit is clear drives the interrupt line. The interrupt tells local software that the entry may need reloading.

Software reaches the table, the event bits and the mask bits through a simple word-wide register port. Writes to the register port take effect at the next clock edge, and reads return data in the same cycle. Each translation result is registered and appears one cycle after its request.

Top module: `pgwin_xlat`

## Requirements
- R1: After reset the block shows no response, `irq` is low, every entry and event word reads 0, and both mask words (register indices 66 and 67) read 32'hFFFFFFFF.
- R2: `cfg_pg_log2` is the log2 of the page size in bytes. Values below 8 behave as 8 and values above 25 behave as 25.
- R3: A request is inside the window when `req_addr - cfg_win_base` does not wrap below zero and, shifted right by the page-size log2, gives a value below 64. That value is the page index.
- R4: `rsp_vld` follows `req_vld` by exactly one cycle. For an inside request with a usable entry, `rsp_hit` is 1 and `rsp_addr` is the entry's base bits above the page-size log2 joined to the page offset. Otherwise `rsp_addr` echoes the request address.
- R5: Register indices 0..63 hold the entries. On write, bit 0 is the usable flag, bit 1 is the prefetch flag and bits 31:8 are the base. On read, bits 3:2 and every base bit below the page-size log2 read 0.
- R6: `rsp_pref` is 1 only for a hit read whose entry has the prefetch flag set.
- R7: An inside write to an unusable entry gives `rsp_hit`=0 and pulses `rsp_err` unless `cfg_err_dis` is 1.
- R8: An inside read to an unusable entry gives `rsp_ones` when `cfg_abort_mode` is 0, and gives `rsp_tabort` when it is 1.
- R9: A hit sets the page's event bit when the addressed Dword is the last one in the page, or when `req_last_dw` is 1. A request that misses the window or hits an unusable entry sets no event.
- R10: The event words (indices 64 and 65, for pages 0-31 and 32-63) clear the bits written as one. If an event is set in the same cycle as it is cleared, the set wins.
- R11: `irq` is 1 exactly when some event bit is set and the matching mask bit (indices 66 and 67) is 0.
- R12: A request outside the window gives `rsp_hit`, `rsp_pref`, `rsp_ones`, `rsp_tabort` and `rsp_err` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pg_log2 | input | 5 | Log2 of the page size, clamped to 8..25 |
| cfg_win_base | input | 32 | Start address of the window |
| cfg_abort_mode | input | 1 | Refused read: 0 returns all-ones, 1 reports target abort |
| cfg_err_dis | input | 1 | Suppresses the error pulse for refused writes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_vld | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_last_dw | input | 1 | Transfer data reached the final Dword of its page |
| rsp_vld | output | 1 | Response present |
| rsp_addr | output | 32 | Translated (or echoed) address |
| rsp_hit | output | 1 | Inside the window with a usable entry |
| rsp_pref | output | 1 | Read may be prefetched |
| rsp_ones | output | 1 | Return all-ones read data |
| rsp_tabort | output | 1 | Signal a target abort |
| rsp_err | output | 1 | Error pulse for a dropped write |
| irq | output | 1 | Unmasked event pending |

## Verification
The hardest case to reach from the ports is an event that arrives in the same cycle as software clears it. A second hard case is the edge of a window built from the largest pages, because the window then covers half the address space and the subtraction can wrap. The random loop handles the first case by issuing event-word clears in the same cycles as its requests. It also draws page-size codes from beyond both clamp limits, places addresses just outside both window edges, and biases offsets toward the last Dword of a page.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
   localparam int unsigned ADDR_W     = 32;
   localparam int unsigned BASE_LSB   = 8;
   localparam int unsigned BASE_W     = ADDR_W - BASE_LSB;
   localparam int unsigned LG_W       = 5;
   localparam logic [LG_W-1:0] LG_MIN = 5'd8;
   localparam logic [LG_W-1:0] LG_MAX = 5'd25;

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic              pref;
      logic              usable;
   } pg_ent_t;

   function automatic logic [LG_W-1:0] clamp_lg(input logic [LG_W-1:0] code);
      if (code < LG_MIN)      return LG_MIN;
      else if (code > LG_MAX) return LG_MAX;
      else                    return code;
   endfunction
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
   import pgwin_pkg::*;
#(
   parameter int unsigned PAGES = 64,
   localparam int unsigned IDX_W = $clog2(PAGES)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [LG_W-1:0]   lg,
   output logic              inwin,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] pmask,
   output logic [ADDR_W-1:0] offset,
   output logic              last_dw
);
   logic [ADDR_W:0]   diff;
   logic [ADDR_W-1:0] pg_full;

   always_comb begin
      diff    = {1'b0, addr} - {1'b0, base};
      pg_full = diff[ADDR_W-1:0] >> lg;
      pmask   = (ADDR_W'(1) << lg) - ADDR_W'(1);
      offset  = diff[ADDR_W-1:0] & pmask;
      inwin   = !diff[ADDR_W] && (pg_full[ADDR_W-1:IDX_W] == '0);
      idx     = pg_full[IDX_W-1:0];
      last_dw = ((offset | ADDR_W'(3)) == pmask);
   end
endmodule

// File: rtl/pgwin_lut.sv
module pgwin_lut
   import pgwin_pkg::*;
#(
   parameter int unsigned PAGES = 64,
   localparam int unsigned IDX_W = $clog2(PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  xl_idx,
   output pg_ent_t           xl_ent,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [ADDR_W-1:0] pmask,
   output logic [ADDR_W-1:0] rb_data
);
   pg_ent_t tbl [PAGES];
   pg_ent_t rb_ent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGES; i++) tbl[i] <= '0;
      end else if (wr_en) begin
         tbl[wr_idx] <= '{base: wr_data[ADDR_W-1:BASE_LSB],
                          pref: wr_data[1], usable: wr_data[0]};
      end
   end

   always_comb begin
      xl_ent  = tbl[xl_idx];
      rb_ent  = tbl[rb_idx];
      rb_data = ({rb_ent.base, {BASE_LSB{1'b0}}} & ~pmask)
              | {{(ADDR_W-2){1'b0}}, rb_ent.pref, rb_ent.usable};
   end
endmodule

// File: rtl/pgwin_evt.sv
module pgwin_evt #(
   parameter int unsigned PAGES  = 64,
   parameter int unsigned WORD_W = 32,
   localparam int unsigned IDX_W = $clog2(PAGES),
   localparam int unsigned NW    = PAGES / WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [IDX_W-1:0]  set_idx,
   input  logic [NW-1:0]     clr_we,
   input  logic [NW-1:0]     msk_we,
   input  logic [WORD_W-1:0] wdata,
   output logic [PAGES-1:0]  evt,
   output logic [PAGES-1:0]  msk,
   output logic              irq
);
   for (genvar w = 0; w < NW; w++) begin : g_word
      for (genvar b = 0; b < WORD_W; b++) begin : g_bit
         localparam int unsigned P = w * WORD_W + b;
         logic set_here;
         assign set_here = set_en && (set_idx == IDX_W'(P));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               evt[P] <= 1'b0;
               msk[P] <= 1'b1;
            end else begin
               evt[P] <= set_here | (evt[P] & ~(clr_we[w] & wdata[b]));
               if (msk_we[w]) msk[P] <= wdata[b];
            end
         end
      end
   end

   assign irq = |(evt & ~msk);
endmodule

// File: rtl/pgwin_xlat.sv
module pgwin_xlat
   import pgwin_pkg::*;
#(
   parameter int unsigned PAGES  = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RA_W   = 7,
   localparam int unsigned IDX_W = $clog2(PAGES),
   localparam int unsigned NW    = PAGES / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LG_W-1:0]   cfg_pg_log2,
   input  logic [ADDR_W-1:0] cfg_win_base,
   input  logic              cfg_abort_mode,
   input  logic              cfg_err_dis,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   input  logic              req_last_dw,
   output logic              rsp_vld,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_hit,
   output logic              rsp_pref,
   output logic              rsp_ones,
   output logic              rsp_tabort,
   output logic              rsp_err,
   output logic              irq
);
   if (PAGES != 64)          begin : g_bad_pages $error("PAGES must be 64"); end
   if (DATA_W != ADDR_W)     begin : g_bad_data  $error("DATA_W must equal ADDR_W"); end
   if (PAGES % DATA_W != 0)  begin : g_bad_split $error("PAGES must split into words"); end
   if ((1 << RA_W) < PAGES + 2 * NW) begin : g_bad_ra $error("RA_W too small"); end

   localparam int unsigned EVT_BASE = PAGES;
   localparam int unsigned MSK_BASE = PAGES + NW;

   logic [LG_W-1:0]   lg;
   logic              inwin, last_dw;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] pmask, offset, rb_data, trans;
   pg_ent_t           ent;
   logic [PAGES-1:0]  evt, msk;
   logic [NW-1:0]     clr_we, msk_we;
   logic              hit_c, miss_c, ent_wr;

   assign lg = clamp_lg(cfg_pg_log2);

   pgwin_decode #(.PAGES(PAGES)) u_dec (
      .addr(req_addr), .base(cfg_win_base), .lg(lg), .inwin(inwin),
      .idx(idx), .pmask(pmask), .offset(offset), .last_dw(last_dw));

   assign ent_wr = reg_we && (reg_addr < RA_W'(PAGES));

   pgwin_lut #(.PAGES(PAGES)) u_lut (
      .clk(clk), .rst_n(rst_n), .wr_en(ent_wr), .wr_idx(reg_addr[IDX_W-1:0]),
      .wr_data(reg_wdata), .xl_idx(idx), .xl_ent(ent),
      .rb_idx(reg_addr[IDX_W-1:0]), .pmask(pmask), .rb_data(rb_data));

   for (genvar w = 0; w < NW; w++) begin : g_we
      assign clr_we[w] = reg_we && (reg_addr == RA_W'(EVT_BASE + w));
      assign msk_we[w] = reg_we && (reg_addr == RA_W'(MSK_BASE + w));
   end

   assign hit_c  = req_vld && inwin && ent.usable;
   assign miss_c = req_vld && inwin && !ent.usable;
   assign trans  = ({ent.base, {BASE_LSB{1'b0}}} & ~pmask) | offset;

   pgwin_evt #(.PAGES(PAGES), .WORD_W(DATA_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .set_en(hit_c && (last_dw || req_last_dw)),
      .set_idx(idx), .clr_we(clr_we), .msk_we(msk_we), .wdata(reg_wdata),
      .evt(evt), .msk(msk), .irq(irq));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr < RA_W'(PAGES)) reg_rdata = rb_data;
      for (int w = 0; w < int'(NW); w++) begin
         if (reg_addr == RA_W'(EVT_BASE + w)) reg_rdata = evt[w*DATA_W +: DATA_W];
         if (reg_addr == RA_W'(MSK_BASE + w)) reg_rdata = msk[w*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld    <= 1'b0;
         rsp_addr   <= '0;
         rsp_hit    <= 1'b0;
         rsp_pref   <= 1'b0;
         rsp_ones   <= 1'b0;
         rsp_tabort <= 1'b0;
         rsp_err    <= 1'b0;
      end else begin
         rsp_vld    <= req_vld;
         rsp_addr   <= hit_c ? trans : req_addr;
         rsp_hit    <= hit_c;
         rsp_pref   <= hit_c && !req_wr && ent.pref;
         rsp_ones   <= miss_c && !req_wr && !cfg_abort_mode;
         rsp_tabort <= miss_c && !req_wr && cfg_abort_mode;
         rsp_err    <= miss_c && req_wr && !cfg_err_dis;
      end
   end
endmodule

// File: rtl/pgwin_chk.sv
module pgwin_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_abort_mode,
   input logic        cfg_err_dis,
   input logic        req_vld,
   input logic [31:0] req_addr,
   input logic        req_wr,
   input logic        rsp_vld,
   input logic [31:0] rsp_addr,
   input logic        rsp_hit,
   input logic        rsp_pref,
   input logic        rsp_ones,
   input logic        rsp_tabort,
   input logic        rsp_err
);
   p_rsp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);
   p_no_spurious_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);
   p_hit_keeps_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_addr[7:0] == $past(req_addr[7:0]));
   p_pref_read_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pref |-> rsp_hit && !$past(req_wr));
   p_err_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(req_vld && req_wr && !cfg_err_dis));
   p_ones_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ones |-> $past(req_vld && !req_wr && !cfg_abort_mode));
   p_tabort_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_tabort |-> $past(req_vld && !req_wr && cfg_abort_mode));
   p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rsp_hit, rsp_ones, rsp_tabort, rsp_err}) <= 1);
endmodule

bind pgwin_xlat pgwin_chk u_chk (.*);

// File: tb/pgwin_xlat_tb.sv
module pgwin_xlat_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_pg_log2 = 5'd12;
   logic [31:0] cfg_win_base = 32'h4000_0000;
   logic        cfg_abort_mode = 1'b0, cfg_err_dis = 1'b0;
   logic        reg_we = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        req_vld = 1'b0, req_wr = 1'b0, req_last_dw = 1'b0;
   logic [31:0] req_addr = '0, rsp_addr;
   logic        rsp_vld, rsp_hit, rsp_pref, rsp_ones, rsp_tabort, rsp_err, irq;

   int unsigned n_chk = 0, n_err = 0, cyc = 0;
   bit          done = 1'b0;

   logic [31:0] m_ent [64];
   logic [63:0] m_evt, m_msk;

   always #4 clk = ~clk;

   pgwin_xlat u_dut (.*);

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   function automatic logic [4:0] m_lg();
      if (cfg_pg_log2 < 8) return 5'd8;
      if (cfg_pg_log2 > 25) return 5'd25;
      return cfg_pg_log2;
   endfunction

   function automatic logic [31:0] m_pmask();
      return (32'h1 << m_lg()) - 32'h1;
   endfunction

   function automatic logic [31:0] m_rb(input int i);
      return (m_ent[i] & ~m_pmask()) | (m_ent[i] & 32'h3);
   endfunction

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string rq);
      reg_we = 1'b0; reg_addr = a; #1;
      check(rq, reg_rdata, exp);
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
      if (a < 64) m_ent[a] = d;
      else if (a == 64) m_evt[31:0]  = m_evt[31:0]  & ~d;
      else if (a == 65) m_evt[63:32] = m_evt[63:32] & ~d;
      else if (a == 66) m_msk[31:0]  = d;
      else if (a == 67) m_msk[63:32] = d;
   endtask

   // Issue one request, optionally with a same-cycle event clear, and check all outputs.
   task automatic req(input logic [31:0] a, input logic w, input logic ldw,
                      input bit do_clr, input logic [6:0] clr_a, input logic [31:0] clr_d);
      logic [32:0] diff;
      logic [31:0] pm, pg, e, xa;
      logic        inw, hit, miss, setev;
      int          ix;
      pm   = m_pmask();
      diff = {1'b0, a} - {1'b0, cfg_win_base};
      pg   = diff[31:0] >> m_lg();
      inw  = !diff[32] && pg < 64;
      ix   = int'(pg[5:0]);
      e    = m_ent[ix];
      hit  = inw && e[0];
      miss = inw && !e[0];
      xa   = hit ? ((e & 32'hFFFF_FF00 & ~pm) | (diff[31:0] & pm)) : a;
      setev = hit && (ldw || ((diff[31:0] & pm) | 32'h3) == pm);
      req_vld = 1'b1; req_addr = a; req_wr = w; req_last_dw = ldw;
      if (do_clr) begin reg_we = 1'b1; reg_addr = clr_a; reg_wdata = clr_d; end
      step();
      req_vld = 1'b0; reg_we = 1'b0;
      if (do_clr) begin
         if (clr_a == 64) m_evt[31:0]  = m_evt[31:0]  & ~clr_d;
         else             m_evt[63:32] = m_evt[63:32] & ~clr_d;
      end
      if (setev) m_evt[ix] = 1'b1;
      check("R4 rsp_vld",  32'(rsp_vld), 32'h1);
      check("R4 rsp_addr", rsp_addr, xa);
      check("R3/R12 rsp_hit", 32'(rsp_hit), 32'(hit));
      check("R6 rsp_pref", 32'(rsp_pref), 32'(hit && !w && e[1]));
      check("R7 rsp_err",  32'(rsp_err), 32'(miss && w && !cfg_err_dis));
      check("R8 rsp_ones", 32'(rsp_ones), 32'(miss && !w && !cfg_abort_mode));
      check("R8 rsp_tabort", 32'(rsp_tabort), 32'(miss && !w && cfg_abort_mode));
      rd(7'd64, m_evt[31:0],  "R9/R10 evt lo");
      rd(7'd65, m_evt[63:32], "R9/R10 evt hi");
      check("R11 irq", 32'(irq), 32'(|(m_evt & ~m_msk)));
   endtask

   function automatic logic [31:0] in_addr(input int pgi, input bit last);
      logic [31:0] off;
      off = $urandom() & m_pmask();
      if (last) off = (m_pmask() & ~32'h3) | ($urandom() & 32'h3);
      return cfg_win_base + (32'(pgi) << m_lg()) + off;
   endfunction

   initial begin
      logic [31:0] a, d;
      int          k;
      void'($urandom(32'd5150));
      for (int i = 0; i < 64; i++) m_ent[i] = '0;
      m_evt = '0; m_msk = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rsp_vld", 32'(rsp_vld), 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      rd(7'd5,  32'h0, "R1 entry");
      rd(7'd64, 32'h0, "R1 evt lo");
      rd(7'd65, 32'h0, "R1 evt hi");
      rd(7'd66, 32'hFFFF_FFFF, "R1 mask lo");
      rd(7'd67, 32'hFFFF_FFFF, "R1 mask hi");
      // R5 readback of reserved and control bits
      wr(7'd5, 32'h1234_5FFF);
      rd(7'd5, 32'h1234_5003, "R5 readback lg12");
      // R2 clamp low and high
      cfg_pg_log2 = 5'd3;  rd(7'd5, 32'h1234_5F03, "R2 clamp to 8");
      cfg_pg_log2 = 5'd31; rd(7'd5, 32'h1200_0003, "R2 clamp to 25");
      cfg_pg_log2 = 5'd12;
      for (int i = 0; i < 64; i++) wr(7'(i), $urandom());
      wr(7'd9, 32'hABCD_E003);
      wr(7'd10, 32'h0000_0000);
      wr(7'd66, 32'h0000_0000);
      // R4/R9 hit at the last Dword of page 9, R11 irq rises
      req(in_addr(9, 1'b1), 1'b0, 1'b0, 1'b0, 7'd64, 32'h0);
      // R7/R8 unusable page 10, both abort modes and error disable
      req(in_addr(10, 1'b0), 1'b1, 1'b0, 1'b0, 7'd64, 32'h0);
      cfg_err_dis = 1'b1;
      req(in_addr(10, 1'b0), 1'b1, 1'b0, 1'b0, 7'd64, 32'h0);
      req(in_addr(10, 1'b1), 1'b0, 1'b1, 1'b0, 7'd64, 32'h0);
      cfg_abort_mode = 1'b1;
      req(in_addr(10, 1'b0), 1'b0, 1'b0, 1'b0, 7'd64, 32'h0);
      // R10 set and clear of page 9 in the same cycle: set wins
      req(in_addr(9, 1'b1), 1'b1, 1'b0, 1'b1, 7'd64, 32'h0000_0200);
      wr(7'd64, 32'h0000_0200);
      rd(7'd64, m_evt[31:0], "R10 clear");
      check("R11 irq after clear", 32'(irq), 32'(|(m_evt & ~m_msk)));
      // R12 just outside both edges
      req(cfg_win_base - 32'h1, 1'b0, 1'b1, 1'b0, 7'd64, 32'h0);
      req(cfg_win_base + (32'd64 << m_lg()), 1'b0, 1'b1, 1'b0, 7'd64, 32'h0);
      // random phase
      for (int it = 0; it < 600; it++) begin
         if (it % 50 == 0) begin
            cfg_pg_log2 = 5'($urandom_range(0, 31));
            cfg_win_base = $urandom() & ~32'hFF;
            cfg_abort_mode = 1'($urandom());
            cfg_err_dis = 1'($urandom());
            wr(7'(66 + $urandom_range(0, 1)), $urandom());
         end
         if ($urandom_range(0, 9) == 0) wr(7'($urandom_range(0, 63)), $urandom());
         k = $urandom_range(0, 9);
         if (k == 0)      a = cfg_win_base - 32'($urandom_range(1, 4096));
         else if (k == 1) a = cfg_win_base + (32'd64 << m_lg()) + 32'($urandom_range(0, 4096));
         else             a = in_addr($urandom_range(0, 63), $urandom_range(0, 2) == 0);
         d = $urandom();
         req(a, 1'($urandom()), $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0,
             7'(64 + $urandom_range(0, 1)), d);
      end
      for (int i = 0; i < 64; i++) rd(7'(i), m_rb(i), "R5 final readback");
      rd(7'd66, m_msk[31:0], "R11 mask lo");
      rd(7'd67, m_msk[63:32], "R11 mask hi");
      finish_run();
   end
endmodule